// File: doc/BRIEF.md
# Parallel MIDI Host Port

This block sits between a microprocessor bus and a synthesizer core and lets the host exchange MIDI bytes with that core. The host sees an 8-bit bidirectional data bus, one address bit, and active-low chip select, read and write strobes. With the address bit low the host reaches a data register: writes go into a small queue towards the synthesizer, and reads return the one-byte receive slot. With the address bit high the host reads a status byte or writes a command.

A second job is routing the serial MIDI stream, which arrives as already assembled bytes with a one-cycle valid flag. After reset, or after the port-reset command, those bytes are passed straight to the synthesizer. After the UART-mode command they go into the receive slot instead, and the interrupt line tells the host that a byte is waiting. The host strobes are asynchronous to the core clock and are brought in through a two-flop synchronizer before any edge is acted on.

Top module: `midi_host_port`

## Requirements
- R1: After reset the interrupt is low, serial bytes are routed to the synthesizer, the receive slot and the host-to-synth queue are empty and the overrun flag is low.
- R2: The data bus is driven only while chip select and read strobe are both low; then it carries the receive byte when the address bit is 0 and the status byte when it is 1, and status bits 5 to 0 are always 1.
- R3: Status bit 7 is 0 exactly while the receive slot holds a byte; status bit 6 is 1 exactly while the host-to-synth queue is full.
- R4: A write with the address bit 0 captures the bus value at the rising edge of the write strobe and appends it to a queue of DEPTH entries (default 4); entries leave at fifo_byte with fifo_valid, one per cycle with fifo_ready high, in write order.
- R5: A data write made while the queue is full changes neither the queue contents nor their order.
- R6: A command write (address bit 1) of 0x3F enters UART mode, 0xFF returns to synthesizer routing and clears the overrun flag; each of these two loads the acknowledge byte 0xFE into the receive slot; any other command value has no effect.
- R7: The interrupt is high while the receive slot holds a byte; a data read, acted on at the rising edge of the read strobe, clears it, and a status read does not.
- R8: A byte that reaches a full receive slot replaces the old byte and sets the overrun flag, which stays set until reset or the 0xFF command.
- R9: In synthesizer routing a serial byte appears on synth_byte with synth_valid one cycle later and does not touch the receive slot.
- R10: In UART mode a serial byte goes to the receive slot and synth_valid stays low.
- R11: A strobe rising edge is acted on at the third core clock edge after it; a serial byte loaded at that same edge as a data-read acknowledge stays pending, while one loaded earlier is consumed by that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| host_a0 | input | 1 | Register select: 0 data, 1 status/command |
| host_cs_n | input | 1 | Chip select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_d | inout | 8 | Host data bus, high impedance unless read |
| host_irq | output | 1 | High while a received byte waits |
| ser_byte | input | 8 | Byte from the serial MIDI receiver |
| ser_valid | input | 1 | One-cycle valid for ser_byte |
| synth_byte | output | 8 | Serial byte forwarded to the synthesizer |
| synth_valid | output | 1 | One-cycle valid for synth_byte |
| fifo_byte | output | 8 | Head of the host-to-synth queue |
| fifo_valid | output | 1 | Queue holds at least one byte |
| fifo_ready | input | 1 | Synthesizer takes the head byte |
| uart_mode | output | 1 | High when serial bytes go to the host |
| rx_overrun | output | 1 | Sticky flag: a received byte was lost |

## Verification
The collision that matters is a serial byte landing in the receive slot in the very cycle that a host data read is acknowledged and clears it. The bench provokes it by raising the read strobe and then pulsing ser_valid at each of four cycle offsets from that rise, so one offset lands exactly on the acknowledge edge. It judges each offset by the interrupt and a follow-up read: offsets before the acknowledge must leave the slot empty, and offsets at or after it must leave the new byte pending and readable.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;
  typedef logic [7:0] mbyte_t;

  localparam mbyte_t CMD_PORT_RESET = 8'hFF;
  localparam mbyte_t CMD_UART_ENTER = 8'h3F;
  localparam mbyte_t ACK_BYTE       = 8'hFE;

  // bit 7 low: byte waiting; bit 6 high: queue full; rest read as 1
  function automatic mbyte_t make_status(input logic rx_full, input logic q_full);
    return {~rx_full, q_full, 6'b111111};
  endfunction
endpackage

// File: rtl/mpb_sync.sv
module mpb_sync #(
  parameter int W       = 12,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] pipe [0:STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RST_VAL;
    else     pipe[0] <= din;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= RST_VAL;
      else     pipe[i] <= pipe[i-1];
    end
  end

  assign cur  = pipe[STAGES-1];
  assign prev = pipe[STAGES];
endmodule

// File: rtl/mpb_fifo.sv
module mpb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         pop_valid,
  output logic [W-1:0] pop_data,
  input  logic         pop_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [0:DEPTH-1];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full      = (count == CW'(DEPTH));
  assign pop_valid = (count != '0);
  assign do_push   = push && !full;
  assign do_pop    = pop_valid && pop_ready;
  assign pop_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5: a push against a full queue leaves it full and the write pointer unmoved
  a_r5_full_push_ignored: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop_ready) |=> (full && $stable(wr_ptr)));

  // R4: an accepted push makes the queue non-empty
  a_r4_push_visible: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> pop_valid);
endmodule

// File: rtl/mpb_rx_slot.sv
module mpb_rx_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         consume,
  input  logic         drop,
  input  logic         clr_ovr,
  output logic         full,
  output logic [W-1:0] data,
  output logic         overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full    <= 1'b0;
      data    <= '0;
      overrun <= 1'b0;
    end else begin
      if (load) begin
        data <= load_data;
        full <= 1'b1;
      end else if (consume) begin
        full <= 1'b0;
      end
      if (clr_ovr)                               overrun <= 1'b0;
      else if ((load && full && !consume) || drop) overrun <= 1'b1;
    end
  end

  // R11: a load in the acknowledge cycle keeps the slot occupied
  a_r11_load_wins: assert property (@(posedge clk) disable iff (rst)
    (load && consume) |=> full);

  // R8: overwriting a pending byte raises the sticky flag
  a_r8_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (load && full && !consume && !clr_ovr) |=> overrun);

  // R7: a consume with no new load empties the slot
  a_r7_consume_clears: assert property (@(posedge clk) disable iff (rst)
    (consume && !load) |=> !full);
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
  import midi_port_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_a0,
  input  logic       host_cs_n,
  input  logic       host_rd_n,
  input  logic       host_wr_n,
  inout  wire  [7:0] host_d,
  output logic       host_irq,
  input  logic [7:0] ser_byte,
  input  logic       ser_valid,
  output logic [7:0] synth_byte,
  output logic       synth_valid,
  output logic [7:0] fifo_byte,
  output logic       fifo_valid,
  input  logic       fifo_ready,
  output logic       uart_mode,
  output logic       rx_overrun
);
  localparam int PW = 12;
  localparam int B_CS = 11;
  localparam int B_RD = 10;
  localparam int B_WR = 9;
  localparam int B_A0 = 8;
  localparam logic [PW-1:0] PIN_IDLE = {3'b111, 1'b0, 8'h00};

  logic [PW-1:0] pins, p_cur, p_prev;
  logic          rd_ack, data_rd_ack, wr_end, data_wr, ctl_wr;
  logic          cmd_reset, cmd_uart, cmd_ack;
  logic          ser_to_host, slot_load, slot_drop;
  mbyte_t        slot_in, d_cap, rx_data, rd_word;
  logic          rx_full, q_full, rd_active;

  assign pins = {host_cs_n, host_rd_n, host_wr_n, host_a0, host_d};

  mpb_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .din(pins), .cur(p_cur), .prev(p_prev)
  );

  // strobe rising edges, qualified by chip select seen low before the edge
  assign d_cap       = p_prev[7:0];
  assign rd_ack      = !p_prev[B_CS] && !p_prev[B_RD] && p_cur[B_RD];
  assign wr_end      = !p_prev[B_CS] && !p_prev[B_WR] && p_cur[B_WR];
  assign data_rd_ack = rd_ack && !p_prev[B_A0];
  assign data_wr     = wr_end && !p_prev[B_A0];
  assign ctl_wr      = wr_end &&  p_prev[B_A0];
  assign cmd_reset   = ctl_wr && (d_cap == CMD_PORT_RESET);
  assign cmd_uart    = ctl_wr && (d_cap == CMD_UART_ENTER);
  assign cmd_ack     = cmd_reset || cmd_uart;

  always_ff @(posedge clk) begin
    if (rst)            uart_mode <= 1'b0;
    else if (cmd_reset) uart_mode <= 1'b0;
    else if (cmd_uart)  uart_mode <= 1'b1;
  end

  // routing of the serial stream
  assign ser_to_host = ser_valid && uart_mode;
  assign slot_load   = cmd_ack || ser_to_host;
  assign slot_in     = cmd_ack ? ACK_BYTE : ser_byte;
  assign slot_drop   = cmd_ack && ser_to_host;

  always_ff @(posedge clk) begin
    if (rst) begin
      synth_valid <= 1'b0;
      synth_byte  <= '0;
    end else begin
      synth_valid <= ser_valid && !uart_mode;
      if (ser_valid && !uart_mode) synth_byte <= ser_byte;
    end
  end

  mpb_rx_slot #(.W(8)) u_rx (
    .clk(clk), .rst(rst),
    .load(slot_load), .load_data(slot_in),
    .consume(data_rd_ack), .drop(slot_drop), .clr_ovr(cmd_reset),
    .full(rx_full), .data(rx_data), .overrun(rx_overrun)
  );

  mpb_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_q (
    .clk(clk), .rst(rst),
    .push(data_wr), .push_data(d_cap), .full(q_full),
    .pop_valid(fifo_valid), .pop_data(fifo_byte), .pop_ready(fifo_ready)
  );

  assign host_irq  = rx_full;
  assign rd_active = !host_cs_n && !host_rd_n;
  assign rd_word   = host_a0 ? make_status(rx_full, q_full) : rx_data;
  assign host_d    = rd_active ? rd_word : 8'bz;

  // R6: mode commands take effect on the next edge
  a_r6_uart_enter: assert property (@(posedge clk) disable iff (rst)
    cmd_uart |=> (uart_mode && host_irq));
  a_r6_port_reset: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |=> (!uart_mode && !rx_overrun && host_irq));

  // R9: synthesizer routing forwards the byte one cycle later
  a_r9_forward: assert property (@(posedge clk) disable iff (rst)
    (ser_valid && !uart_mode) |=> (synth_valid && synth_byte == $past(ser_byte)));

  // R10: UART routing keeps the synthesizer side silent
  a_r10_no_forward: assert property (@(posedge clk) disable iff (rst)
    (ser_valid && uart_mode) |=> !synth_valid);
endmodule

// File: tb/tb_midi_host_port.sv
module tb_midi_host_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       a0 = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] drv = 8'h00;
  logic       drv_en = 1'b0;
  wire  [7:0] host_d;
  logic       irq;
  logic [7:0] ser_byte = 8'h00;
  logic       ser_valid = 1'b0;
  logic [7:0] synth_byte, fifo_byte;
  logic       synth_valid, fifo_valid, uart_mode, rx_overrun;
  logic       fifo_ready = 1'b0;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign host_d = drv_en ? drv : 8'bz;

  midi_host_port dut (
    .clk(clk), .rst(rst), .host_a0(a0), .host_cs_n(cs_n), .host_rd_n(rd_n),
    .host_wr_n(wr_n), .host_d(host_d), .host_irq(irq),
    .ser_byte(ser_byte), .ser_valid(ser_valid),
    .synth_byte(synth_byte), .synth_valid(synth_valid),
    .fifo_byte(fifo_byte), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .uart_mode(uart_mode), .rx_overrun(rx_overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic sel, input logic [7:0] v);
    @(negedge clk);
    a0 = sel; drv = v; drv_en = 1'b1; cs_n = 1'b0;
    wait_n(2); wr_n = 1'b0;
    wait_n(3); wr_n = 1'b1;
    wait_n(4); cs_n = 1'b1; drv_en = 1'b0;
    wait_n(2);
  endtask

  task automatic host_read(input logic sel, output logic [7:0] v);
    @(negedge clk);
    a0 = sel; cs_n = 1'b0;
    wait_n(2); rd_n = 1'b0;
    wait_n(3); v = host_d;
    rd_n = 1'b1;
    wait_n(4); cs_n = 1'b1;
    wait_n(2);
  endtask

  task automatic ser_send(input logic [7:0] b);
    @(negedge clk);
    ser_byte = b; ser_valid = 1'b1;
    @(negedge clk);
    ser_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    chk("R1 irq after reset", irq, 0);
    chk("R1 routing after reset", uart_mode, 0);
    chk("R1 overrun after reset", rx_overrun, 0);
    chk("R1 queue empty after reset", fifo_valid, 0);
    // bus released while idle: a value placed on it reads back intact
    @(negedge clk); drv = 8'hA5; drv_en = 1'b1;
    @(negedge clk); chk("R2 bus undriven when idle", host_d, 8'hA5);
    drv_en = 1'b0;
    host_read(1'b1, v);
    chk("R3 status empty/not full", v, 8'hBF);
  endtask

  task automatic t_synth_route();
    @(negedge clk); ser_byte = 8'h90; ser_valid = 1'b1;
    @(negedge clk); ser_valid = 1'b0;
    chk("R9 synth_valid next cycle", synth_valid, 1);
    chk("R9 synth_byte", synth_byte, 8'h90);
    @(negedge clk);
    chk("R9 synth_valid single pulse", synth_valid, 0);
    chk("R9 receive slot untouched", irq, 0);
  endtask

  task automatic t_queue();
    logic [7:0] v;
    for (int i = 0; i < 4; i++) host_write(1'b0, 8'h10 + 8'(i));
    host_read(1'b1, v);
    chk("R3 status queue full", v, 8'hFF);
    host_write(1'b0, 8'h77);
    for (int i = 0; i < 4; i++) begin
      chk("R4 queue valid", fifo_valid, 1);
      chk("R4/R5 queue order", fifo_byte, 8'h10 + 8'(i));
      fifo_ready = 1'b1;
      @(negedge clk);
      fifo_ready = 1'b0;
    end
    chk("R5 write while full dropped", fifo_valid, 0);
    host_read(1'b1, v);
    chk("R3 status queue drained", v, 8'hBF);
  endtask

  task automatic t_enter_uart();
    logic [7:0] v;
    host_write(1'b1, 8'h3F);
    chk("R6 UART mode entered", uart_mode, 1);
    chk("R7 irq on acknowledge", irq, 1);
    host_read(1'b1, v);
    chk("R3 status byte waiting", v, 8'h3F);
    chk("R7 status read keeps irq", irq, 1);
    host_read(1'b0, v);
    chk("R6 acknowledge byte", v, 8'hFE);
    chk("R7 data read clears irq", irq, 0);
  endtask

  task automatic t_uart_route();
    logic [7:0] v;
    ser_byte = 8'h45; ser_valid = 1'b1;
    @(negedge clk); ser_valid = 1'b0;
    chk("R10 no forward in UART mode", synth_valid, 0);
    chk("R10 irq raised", irq, 1);
    host_read(1'b0, v);
    chk("R10 byte readable", v, 8'h45);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    ser_send(8'h11);
    ser_send(8'h22);
    chk("R8 overrun set", rx_overrun, 1);
    host_read(1'b0, v);
    chk("R8 newest byte kept", v, 8'h22);
    chk("R8 overrun sticky after read", rx_overrun, 1);
  endtask

  task automatic t_bad_cmd();
    host_write(1'b1, 8'h12);
    chk("R6 other command: no ack", irq, 0);
    chk("R6 other command: mode kept", uart_mode, 1);
  endtask

  // read acknowledge versus serial byte, swept over the acknowledge edge
  task automatic t_collision();
    logic [7:0] v;
    for (int n = 0; n < 4; n++) begin
      ser_send(8'h30);
      @(negedge clk);
      a0 = 1'b0; cs_n = 1'b0;
      wait_n(2); rd_n = 1'b0;
      wait_n(3);
      rd_n = 1'b1;
      if (n > 0) wait_n(n);
      ser_byte = 8'h60 + 8'(n); ser_valid = 1'b1;
      @(negedge clk); ser_valid = 1'b0;
      wait_n(6); cs_n = 1'b1;
      wait_n(2);
      chk($sformatf("R11 pending after offset %0d", n), irq, (n >= 2) ? 1 : 0);
      if (n >= 2) begin
        host_read(1'b0, v);
        chk($sformatf("R11 kept byte offset %0d", n), v, 8'h60 + 8'(n));
      end
    end
  endtask

  task automatic t_port_reset();
    logic [7:0] v;
    host_write(1'b1, 8'hFF);
    chk("R6 port reset leaves UART mode", uart_mode, 0);
    chk("R6 port reset clears overrun", rx_overrun, 0);
    host_read(1'b0, v);
    chk("R6 reset acknowledge byte", v, 8'hFE);
    ser_send(8'h55);
    chk("R9 routing restored", synth_byte, 8'h55);
    chk("R9 slot idle after restore", irq, 0);
  endtask

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    t_reset_state();
    t_synth_route();
    t_queue();
    t_enter_uart();
    t_uart_route();
    t_overrun();
    t_bad_cmd();
    t_collision();
    t_port_reset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule